// File: doc/BRIEF.md
# Pattern-Counting Frame Analyser

This block watches a byte-wide receive stream of Ethernet frames and sorts each completed frame into one of two bins. A frame lands in the good bin when its destination address, source address and type field match a programmed pattern (each field can be left out of the comparison). Otherwise it lands in the bad bin. A frame whose end is flagged with a receive or CRC error, or one too short to hold the header, also goes to the bad bin. The two counts are exposed on ports together with a three-valued run state.

A test sequence switches the analyser on, which clears both counts, and lets traffic flow. The analyser freezes itself in a hold state once the total number of frames reaches a programmed limit, or once the good count reaches a second limit, whichever comes first. While running, every received byte is forwarded one cycle later. With tagging switched on, a bad frame is forwarded without its end marker and is followed by one extra byte holding a programmed error code, which then carries the end marker.

The block assumes at least one idle cycle between the last byte of a frame and the first byte of the next, and that the enable is raised between frames.

Top module: `frame_analyser`

## Requirements
- R1: While rst_n is low at a clock edge, the run state becomes 0 (off), both counts become 0 and tx_valid becomes 0.
- R2: Run state encoding is 0 = off, 1 = running, 2 = hold. With an_enable low the state is off, and frames are neither counted nor forwarded. Raising an_enable while off moves the state to running and clears both counts at the same edge.
- R3: Header bytes are compared by position: bytes 0-5 against the destination pattern, most significant byte first, bytes 6-11 against the source pattern, and bytes 12-13 against the type pattern, most significant byte first. cmp_en bit 0 enables the destination comparison, bit 1 the source comparison and bit 2 the type comparison. A disabled field never causes a mismatch. A frame with no mismatch adds one to ok_count.
- R4: A frame adds one to nok_count when any enabled field differs, when rx_err is high with its last byte, or when it has fewer than 14 bytes. It never adds to both counts.
- R5: Counts change at the clock edge that samples the last byte (rx_valid and rx_last high) and saturate at 2^CNT_W-1.
- R6: When expect_total is nonzero and ok_count+nok_count reaches it, the state becomes hold at the same edge as the count update. An expect_total of 0 never stops the block.
- R7: When expect_ok is nonzero and ok_count reaches it, the state becomes hold at the same edge as the count update. An expect_ok of 0 never stops the block.
- R8: In hold, frames are ignored and the counts stay frozen until an_enable goes low. A frame still in progress when hold is entered is not counted, and its remaining bytes are not forwarded.
- R9: While running, each byte sampled with rx_valid appears on tx_data with tx_valid one cycle later. The last byte carries tx_last unless it is followed by a trailer.
- R10: With tag_enable high, the last byte of a bad frame is forwarded with tx_last low. In the next cycle err_code is sent with tx_valid and tx_last high. This also happens when that frame triggers hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| an_enable | input | 1 | Analyser on/off control |
| tag_enable | input | 1 | Append error-code trailer to bad frames |
| err_code | input | 8 | Trailer byte value |
| pat_dst | input | 48 | Destination address pattern |
| pat_src | input | 48 | Source address pattern |
| pat_type | input | 16 | Type field pattern |
| cmp_en | input | 3 | Per-field compare enables (dst, src, type) |
| expect_total | input | CNT_W | Total-frame stop limit, 0 = none |
| expect_ok | input | CNT_W | Good-frame stop limit, 0 = none |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_last | input | 1 | Last byte of frame |
| rx_err | input | 1 | Frame error flag, valid with rx_last |
| tx_data | output | 8 | Forwarded byte |
| tx_valid | output | 1 | Forwarded byte strobe |
| tx_last | output | 1 | Last forwarded byte of frame |
| an_state | output | 2 | Run state: 0 off, 1 running, 2 hold |
| ok_count | output | CNT_W | Matching frame count |
| nok_count | output | CNT_W | Mismatching frame count |

## Verification
Three events can share one clock edge. The last byte of the frame that meets a stop limit updates a count, moves the state to hold, and, when that frame is bad and tagging is on, schedules its trailer. The bench provokes this with a limit of three frames where the third frame carries a wrong type field. It then judges the edge by reading the new counts, the hold state and the trailer byte together. Stopping mid-frame is also provoked, by lowering the limit while a frame is half received, and is judged by checking that neither the counts nor the forwarded byte total move.

// File: rtl/an_pkg.sv
// Shared definitions for the frame analyser.
// Assumes nothing beyond a 2-bit state field on the top-level port.
package an_pkg;
    typedef enum logic [1:0] {
        AN_OFF  = 2'd0,
        AN_RUN  = 2'd1,
        AN_HOLD = 2'd2
    } an_state_e;
endpackage

// File: rtl/an_frame_matcher.sv
// Walks the header of each received frame byte by byte and compares
// it with the programmed pattern under per-field enables.
// Raises frame_done with the last byte and gives the verdict on frame_bad.
// Assumes: active low discards any partially seen frame.
module an_frame_matcher #(
    parameter int HDR_LEN = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    input  logic        rx_err,
    input  logic [47:0] pat_dst,
    input  logic [47:0] pat_src,
    input  logic [15:0] pat_type,
    input  logic [2:0]  cmp_en,
    output logic        frame_done,
    output logic        frame_bad
);
    localparam int IDX_W = $clog2(HDR_LEN + 1);
    localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(HDR_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_LEN - 1);

    logic [7:0] dst_b  [6];
    logic [7:0] src_b  [6];
    logic [7:0] type_b [2];

    // Split the pattern fields into bytes in wire order.
    for (genvar g = 0; g < 6; g++) begin : g_addr
        assign dst_b[g] = pat_dst[47-8*g -: 8];
        assign src_b[g] = pat_src[47-8*g -: 8];
    end
    for (genvar g = 0; g < 2; g++) begin : g_type
        assign type_b[g] = pat_type[15-8*g -: 8];
    end

    logic [IDX_W-1:0] idx_q;
    logic             dst_bad_q, src_bad_q, type_bad_q;
    logic             cur_dst_bad, cur_src_bad, cur_type_bad;
    logic [2:0]       src_pos;

    assign src_pos = 3'(idx_q - IDX_W'(6));

    // Compare the current byte against the pattern byte at its position.
    always_comb begin
        cur_dst_bad  = 1'b0;
        cur_src_bad  = 1'b0;
        cur_type_bad = 1'b0;
        if (idx_q < IDX_W'(6))
            cur_dst_bad = rx_data != dst_b[idx_q[2:0]];
        else if (idx_q < IDX_W'(12))
            cur_src_bad = rx_data != src_b[src_pos];
        else if (idx_q < IDX_MAX)
            cur_type_bad = rx_data != type_b[idx_q[0]];
    end

    // Track byte position and accumulated field mismatches per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            idx_q      <= '0;
            dst_bad_q  <= 1'b0;
            src_bad_q  <= 1'b0;
            type_bad_q <= 1'b0;
        end else if (rx_valid) begin
            if (rx_last) begin
                idx_q      <= '0;
                dst_bad_q  <= 1'b0;
                src_bad_q  <= 1'b0;
                type_bad_q <= 1'b0;
            end else begin
                if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
                dst_bad_q  <= dst_bad_q  | cur_dst_bad;
                src_bad_q  <= src_bad_q  | cur_src_bad;
                type_bad_q <= type_bad_q | cur_type_bad;
            end
        end
    end

    assign frame_done = active && rx_valid && rx_last;

    // Verdict at end of frame: field mismatch, error flag or short frame.
    always_comb begin
        frame_bad = (cmp_en[0] && (dst_bad_q  || cur_dst_bad))
                 || (cmp_en[1] && (src_bad_q  || cur_src_bad))
                 || (cmp_en[2] && (type_bad_q || cur_type_bad))
                 || rx_err
                 || (idx_q < IDX_LAST);
    end
endmodule

// File: rtl/an_sat_counter.sv
// Saturating up-counter with synchronous clear.
// Exposes the value it will load at the next edge so that the
// caller can act on the updated count in the same cycle.
// Assumes: clear has priority over inc.
module an_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic [W-1:0] count_nxt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    // Next value: clear, step unless saturated, or hold.
    always_comb begin
        if (clear)                      count_nxt = '0;
        else if (inc && count != MAX)   count_nxt = count + 1'b1;
        else                            count_nxt = count;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end
endmodule

// File: rtl/an_tag_forwarder.sv
// Forwards accepted bytes one cycle late and, for bad frames with
// tagging on, appends one trailer byte that carries the end marker.
// Assumes: at least one idle input cycle after each frame's last byte.
module an_tag_forwarder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_bad,
    input  logic       tag_en,
    input  logic [7:0] code,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    output logic       tx_last
);
    logic pend_q;

    // Output register and pending-trailer flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            pend_q   <= 1'b0;
        end else if (pend_q) begin
            tx_data  <= code;
            tx_valid <= 1'b1;
            tx_last  <= 1'b1;
            pend_q   <= 1'b0;
        end else if (in_valid) begin
            tx_data  <= in_data;
            tx_valid <= 1'b1;
            tx_last  <= in_last && !(tag_en && in_bad);
            pend_q   <= in_last && tag_en && in_bad;
        end else begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_analyser.sv
// Frame analyser top: run-state control, pattern matcher, good/bad
// counters with two stop limits, and the forwarding path with trailer.
// Assumes: an_enable rises between frames; one idle cycle between frames.
module frame_analyser
    import an_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             an_enable,
    input  logic             tag_enable,
    input  logic [7:0]       err_code,
    input  logic [47:0]      pat_dst,
    input  logic [47:0]      pat_src,
    input  logic [15:0]      pat_type,
    input  logic [2:0]       cmp_en,
    input  logic [CNT_W-1:0] expect_total,
    input  logic [CNT_W-1:0] expect_ok,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic             rx_err,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    output logic [1:0]       an_state,
    output logic [CNT_W-1:0] ok_count,
    output logic [CNT_W-1:0] nok_count
);
    localparam int SUM_W = CNT_W + 1;

    an_state_e        st_q;
    logic             run, clr;
    logic             frame_done, frame_bad;
    logic [CNT_W-1:0] ok_nxt, nok_nxt;
    logic [SUM_W-1:0] total_nxt;
    logic             stop_now;

    assign run      = (st_q == AN_RUN);
    assign clr      = (st_q == AN_OFF) && an_enable;
    assign an_state = st_q;

    an_frame_matcher #(.HDR_LEN(14)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (run),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_last    (rx_last),
        .rx_err     (rx_err),
        .pat_dst    (pat_dst),
        .pat_src    (pat_src),
        .pat_type   (pat_type),
        .cmp_en     (cmp_en),
        .frame_done (frame_done),
        .frame_bad  (frame_bad)
    );

    an_sat_counter #(.W(CNT_W)) u_ok_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .inc       (frame_done && !frame_bad),
        .count     (ok_count),
        .count_nxt (ok_nxt)
    );

    an_sat_counter #(.W(CNT_W)) u_nok_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .inc       (frame_done && frame_bad),
        .count     (nok_count),
        .count_nxt (nok_nxt)
    );

    // Stop test on the counts as they will be after this edge.
    always_comb begin
        total_nxt = {1'b0, ok_nxt} + {1'b0, nok_nxt};
        stop_now  = ((expect_total != '0) && (total_nxt >= {1'b0, expect_total}))
                 || ((expect_ok != '0) && (ok_nxt >= expect_ok));
    end

    // Run-state sequencing: off, running, hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          st_q <= AN_OFF;
        else if (!an_enable) st_q <= AN_OFF;
        else begin
            case (st_q)
                AN_OFF:  st_q <= AN_RUN;
                AN_RUN:  st_q <= stop_now ? AN_HOLD : AN_RUN;
                default: st_q <= AN_HOLD;
            endcase
        end
    end

    an_tag_forwarder u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid && run),
        .in_data  (rx_data),
        .in_last  (rx_last),
        .in_bad   (frame_bad),
        .tag_en   (tag_enable),
        .code     (err_code),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last)
    );
endmodule

// File: rtl/an_checker.sv
// Temporal checks on the frame analyser ports, bound to every instance.
// Assumes the one-idle-cycle gap between frames stated for the block.
module an_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             an_enable,
    input logic [7:0]       err_code,
    input logic [CNT_W-1:0] expect_total,
    input logic [CNT_W-1:0] expect_ok,
    input logic [7:0]       rx_data,
    input logic             rx_valid,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_last,
    input logic [1:0]       an_state,
    input logic [CNT_W-1:0] ok_count,
    input logic [CNT_W-1:0] nok_count
);
    logic [CNT_W:0] sum_now;
    assign sum_now = {1'b0, ok_count} + {1'b0, nok_count};

    assert_off_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (an_state == 2'd0 && !an_enable) |=> ($stable(ok_count) && $stable(nok_count)));

    assert_single_bin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !((ok_count != $past(ok_count)) && (nok_count != $past(nok_count))
          && (ok_count != '0)));

    assert_ok_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_count != $past(ok_count)) |->
            (ok_count == $past(ok_count) + 1'b1 || ok_count == '0));

    assert_ok_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ok_count) == '1 && an_state != 2'd0) |-> (ok_count == '1 || ok_count == '0));

    assert_hold_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (an_state == 2'd2 && $past(an_state) == 2'd1) |->
            ((expect_total != '0 && sum_now >= {1'b0, expect_total})
             || (expect_ok != '0 && ok_count >= expect_ok)));

    assert_ok_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (an_state == 2'd1 && expect_ok != '0 && ok_count >= expect_ok) |=> (an_state != 2'd1));

    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (an_state == 2'd2 && $past(an_state) == 2'd2) |->
            ($stable(ok_count) && $stable(nok_count)));

    assert_forward_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(rx_valid)) |-> (tx_data == $past(rx_data)));

    assert_trailer_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !$past(rx_valid)) |-> (tx_last && tx_data == $past(err_code)));
endmodule

bind frame_analyser an_checker #(.CNT_W(CNT_W)) u_an_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .an_enable    (an_enable),
    .err_code     (err_code),
    .expect_total (expect_total),
    .expect_ok    (expect_ok),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .an_state     (an_state),
    .ok_count     (ok_count),
    .nok_count    (nok_count)
);

// File: tb/frame_analyser_tb.sv
// Self-checking bench: table of frames, then directed corner cases.
module frame_analyser_tb;
    localparam int CW = 4;
    localparam logic [47:0] PD = 48'h0A0B0C0D0E0F;
    localparam logic [47:0] PS = 48'h112233445566;
    localparam logic [15:0] PT = 16'h8892;
    localparam logic [7:0]  EC = 8'hE5;

    typedef struct packed {
        logic [47:0] d;
        logic [47:0] s;
        logic [15:0] t;
        logic [7:0]  len;
        logic        err;
        logic        bad;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{PD, PS, PT, 8'd20, 1'b0, 1'b0},
        '{48'h0A0B0C0D0E00, PS, PT, 8'd16, 1'b0, 1'b1},
        '{PD, 48'h912233445566, PT, 8'd14, 1'b0, 1'b1},
        '{PD, PS, 16'h8893, 8'd18, 1'b0, 1'b1},
        '{PD, PS, PT, 8'd15, 1'b1, 1'b1},
        '{PD, PS, PT, 8'd14, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic an_enable = 1'b0, tag_enable = 1'b1;
    logic [7:0] err_code = EC;
    logic [2:0] cmp_en = 3'b111;
    logic [CW-1:0] expect_total = '0, expect_ok = '0;
    logic [7:0] rx_data = '0;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
    logic [7:0] tx_data;
    logic tx_valid, tx_last;
    logic [1:0] an_state;
    logic [CW-1:0] ok_count, nok_count;

    int n_run = 0, n_fail = 0;
    int tx_bytes = 0, tx_frames = 0, cur_len = 0, last_len = 0;
    logic [7:0] last_byte = '0;

    always #2 clk = ~clk;

    frame_analyser #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .tag_enable(tag_enable),
        .err_code(err_code), .pat_dst(PD), .pat_src(PS), .pat_type(PT),
        .cmp_en(cmp_en), .expect_total(expect_total), .expect_ok(expect_ok),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .an_state(an_state), .ok_count(ok_count), .nok_count(nok_count)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (tx_valid) begin
            tx_bytes = tx_bytes + 1;
            cur_len  = cur_len + 1;
            if (tx_last) begin
                tx_frames = tx_frames + 1;
                last_len  = cur_len;
                last_byte = tx_data;
                cur_len   = 0;
            end
        end
    end

    function automatic logic [7:0] fbyte(logic [47:0] d, logic [47:0] s,
                                         logic [15:0] t, int i);
        if (i < 6)       return d[8*(5-i) +: 8];
        else if (i < 12) return s[8*(11-i) +: 8];
        else if (i < 14) return t[8*(13-i) +: 8];
        else             return 8'(i*3 + 1);
    endfunction

    task automatic chk(string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic send_frame(logic [47:0] d, logic [47:0] s, logic [15:0] t,
                              int len, logic err);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fbyte(d, s, t, i);
            rx_last  = (i == len - 1);
            rx_err   = err && (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk); an_enable = 1'b0;
        @(negedge clk); an_enable = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int eo, eb, tf;
        repeat (3) @(negedge clk);
        chk("R1 state in reset", int'(an_state), 0);
        chk("R1 ok_count in reset", int'(ok_count), 0);
        chk("R1 nok_count in reset", int'(nok_count), 0);
        chk("R1 tx_valid in reset", int'(tx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); an_enable = 1'b1;
        @(negedge clk);
        chk("R2 running after enable", int'(an_state), 1);

        // Table of frames with expected verdicts.
        eo = 0; eb = 0;
        for (int v = 0; v < 6; v++) begin
            send_frame(VECS[v].d, VECS[v].s, VECS[v].t, int'(VECS[v].len), VECS[v].err);
            if (VECS[v].bad) eb++; else eo++;
            chk($sformatf("R3 ok_count vec %0d", v), int'(ok_count), eo);
            chk($sformatf("R4 nok_count vec %0d", v), int'(nok_count), eb);
            if (VECS[v].bad) begin
                chk($sformatf("R10 tx length vec %0d", v), last_len, int'(VECS[v].len) + 1);
                chk($sformatf("R10 trailer vec %0d", v), int'(last_byte), int'(EC));
            end else begin
                chk($sformatf("R9 tx length vec %0d", v), last_len, int'(VECS[v].len));
                chk($sformatf("R9 last byte vec %0d", v), int'(last_byte),
                    int'(fbyte(VECS[v].d, VECS[v].s, VECS[v].t, int'(VECS[v].len) - 1)));
            end
        end

        // R4: short frame.
        send_frame(PD, PS, PT, 10, 1'b0);
        chk("R4 short frame nok", int'(nok_count), 5);

        // R3: destination comparison switched off.
        cmp_en = 3'b110;
        send_frame(48'hFFFFFFFFFFFF, PS, PT, 14, 1'b0);
        chk("R3 dst ignored ok", int'(ok_count), 3);
        cmp_en = 3'b111;

        // R9: tagging off, bad frame forwarded unchanged.
        tag_enable = 1'b0;
        send_frame(PD, PS, 16'h0800, 16, 1'b0);
        chk("R9 untagged nok", int'(nok_count), 6);
        chk("R9 untagged length", last_len, 16);
        chk("R9 untagged last byte", int'(last_byte), int'(fbyte(PD, PS, 16'h0800, 15)));
        tag_enable = 1'b1;

        // R2: disabled ignores frames; enabling clears counts.
        @(negedge clk); an_enable = 1'b0;
        @(negedge clk);
        chk("R2 state off", int'(an_state), 0);
        tf = tx_frames;
        send_frame(PD, PS, PT, 14, 1'b0);
        chk("R2 off ok frozen", int'(ok_count), 3);
        chk("R2 off nok frozen", int'(nok_count), 6);
        chk("R2 off no forward", tx_frames, tf);
        an_enable = 1'b1;
        @(negedge clk);
        chk("R2 enable running", int'(an_state), 1);
        chk("R2 enable clears ok", int'(ok_count), 0);
        chk("R2 enable clears nok", int'(nok_count), 0);

        // R6 + R10: total limit reached by a tagged bad frame.
        expect_total = 4'd3;
        send_frame(PD, PS, PT, 14, 1'b0);
        send_frame(PD, PS, PT, 14, 1'b0);
        chk("R6 still running at 2", int'(an_state), 1);
        send_frame(PD, PS, 16'h1234, 14, 1'b0);
        chk("R6 hold at total", int'(an_state), 2);
        chk("R6 ok at hold", int'(ok_count), 2);
        chk("R6 nok at hold", int'(nok_count), 1);
        chk("R10 trailer on stop frame", int'(last_byte), int'(EC));
        chk("R10 length on stop frame", last_len, 15);
        tf = tx_frames;
        send_frame(PD, PS, PT, 14, 1'b0);
        chk("R8 hold ok frozen", int'(ok_count), 2);
        chk("R8 hold nok frozen", int'(nok_count), 1);
        chk("R8 hold no forward", tx_frames, tf);
        chk("R8 hold persists", int'(an_state), 2);

        // R7: good-frame limit.
        expect_total = '0; expect_ok = 4'd2;
        restart();
        send_frame(PD, PS, 16'h1111, 14, 1'b0);
        send_frame(PD, PS, PT, 14, 1'b0);
        chk("R7 running at ok 1", int'(an_state), 1);
        send_frame(PD, PS, PT, 14, 1'b0);
        chk("R7 hold at ok limit", int'(an_state), 2);
        chk("R7 ok at hold", int'(ok_count), 2);
        chk("R7 nok at hold", int'(nok_count), 1);

        // R5: saturation with no limits.
        expect_ok = '0;
        restart();
        for (int k = 0; k < 17; k++) send_frame(PD, PS, PT, 14, 1'b0);
        chk("R5 ok saturates", int'(ok_count), 15);
        chk("R5 nok untouched", int'(nok_count), 0);
        chk("R6 zero limits keep running", int'(an_state), 1);

        // R8: hold entered mid-frame drops the frame.
        restart();
        send_frame(PD, PS, PT, 14, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_last = 1'b0; rx_data = fbyte(PD, PS, PT, i);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        expect_total = 4'd1;
        @(negedge clk);
        chk("R8 hold mid-frame", int'(an_state), 2);
        tf = tx_bytes;
        for (int i = 5; i < 14; i++) begin
            rx_valid = 1'b1; rx_last = (i == 13); rx_data = fbyte(PD, PS, PT, i);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 dropped frame ok", int'(ok_count), 1);
        chk("R8 dropped frame nok", int'(nok_count), 0);
        chk("R8 dropped bytes not forwarded", tx_bytes, tf);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule